// File: doc/BRIEF.md
# Receive FIFO with Error Lock

This block buffers received bytes for a serial controller. A deserializer pushes one byte at a time, together with a parity-error flag and a framing-error flag. The byte goes into a small data queue, and its status goes into a parallel status queue that advances in step with it. An active-low request line asks an external DMA engine to drain the queue whenever data is waiting. A host bus reads the head byte, reads its status and writes a control register.

A head byte that carries a special condition freezes the queue. The special conditions are overrun, framing error, and parity error when parity is configured as special. While the queue is frozen, the status register keeps showing the cause, data reads do not pop, the request line goes inactive and a special-condition interrupt is raised. Software clears the freeze by writing the error-reset command. Reading the data register then removes the faulty byte, and the request line again follows the queue occupancy.

Register select encoding: 0 is the data register, 1 the status register, 2 the control register, and 3 reads as zero. The read strobe is active low. An access begins in the clock cycle where the strobe is first seen low after being high.

Top module: `rx_fifo_errlock`

## Requirements
- R1: After reset the queue is empty, `dreq_n` is 1, `sc_irq` is 0, parity-special is disabled, and the data and status registers read 0.
- R2: While the queue holds at least one byte and is not frozen, `dreq_n` is 0. It is 1 whenever the queue is empty.
- R3: Each read access to the data register (select 0) while not frozen removes the head byte. Bytes leave in arrival order, and the data register shows the head byte before it is removed.
- R4: The status register (select 1) shows the head entry as bit 0 parity error, bit 1 overrun and bit 2 framing error, with all other bits 0. Reading it never removes an entry.
- R5: A head entry with overrun or framing error, or with parity error while parity-special is enabled, freezes the queue. While frozen, `sc_irq` is 1, `dreq_n` is 1, data reads remove nothing, and the head status does not change.
- R6: A parity error with parity-special disabled does not freeze the queue.
- R7: A control write (select 2) with bit 0 set, issued while frozen, releases the freeze. `sc_irq` returns to 0, and the next data read removes the faulty byte.
- R8: In the cycle after a read access to the data register begins, `dreq_n` is 1, whether or not a byte was removed.
- R9: Status reads and control writes leave `dreq_n` unchanged.
- R10: A byte pushed while the queue holds 3 entries replaces the newest entry and sets that entry's overrun bit. The entry count stays at 3.
- R11: Control bit 1 is the parity-special enable. The control register reads back the last written value with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Deserializer delivers a byte this cycle |
| push_data | input | 8 | Received byte |
| push_par_err | input | 1 | Parity error flag for the byte |
| push_frm_err | input | 1 | Framing or end-of-frame error flag for the byte |
| host_sel | input | 2 | Register select (0 data, 1 status, 2 control) |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| dreq_n | output | 1 | Active-low DMA request |
| sc_irq | output | 1 | Special-condition interrupt |

## Verification
The queue is exercised with several input patterns, and each one separates a different behaviour. Clean bytes check ordering and the request line. A parity error is sent first with parity-special off and then with it on, which shows whether the enable is applied. A framing error shows that the freeze does not depend on the enable. Four pushes into three slots check the overrun replacement. Data reads attempted during a freeze, and status reads and control writes at any time, show that only an unfrozen data read removes a byte or releases the request. A behavioural queue model is compared with every output on every clock.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef struct packed {
        logic frm;
        logic ovr;
        logic par;
    } rx_stat_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } host_sel_e;

    localparam int CTRL_ERST_BIT = 0;
    localparam int CTRL_PARS_BIT = 1;

    function automatic logic is_special(rx_stat_t s, logic par_special);
        return s.ovr | s.frm | (s.par & par_special);
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [DW-1:0]               push_data_i,
    input  rx_stat_t                    push_stat_i,
    input  logic                        pop_i,
    output logic [DW-1:0]               head_data_o,
    output rx_stat_t                    head_stat_o,
    output logic [$clog2(DEPTH+1)-1:0]  count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] data;
        rx_stat_t [DEPTH-1:0]     stat;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t        st_d, st_q;
    logic [CW-1:0] cnt_mid;
    logic [PW-1:0] last_idx;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_dec(logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        cnt_mid  = st_q.cnt;
        last_idx = ptr_dec(st_q.wr);
        if (pop_i && (st_q.cnt != '0)) begin
            st_d.rd = ptr_inc(st_q.rd);
            cnt_mid = st_q.cnt - 1'b1;
        end
        if (push_i) begin
            if (cnt_mid < CW'(DEPTH)) begin
                st_d.data[st_q.wr] = push_data_i;
                st_d.stat[st_q.wr] = push_stat_i;
                st_d.wr            = ptr_inc(st_q.wr);
                cnt_mid            = cnt_mid + 1'b1;
            end else begin
                st_d.data[last_idx]     = push_data_i;
                st_d.stat[last_idx]     = push_stat_i;
                st_d.stat[last_idx].ovr = 1'b1;
            end
        end
        st_d.cnt = cnt_mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data_o = st_q.data[st_q.rd];
    assign head_stat_o = st_q.stat[st_q.rd];
    assign count_o     = st_q.cnt;

endmodule

// File: rtl/rxq_host_if.sv
`timescale 1ns/1ps
module rxq_host_if
    import rxq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_i,
    input  logic          rd_n_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          nonempty_i,
    input  logic [DW-1:0] head_data_i,
    input  rx_stat_t      head_stat_i,
    output logic [DW-1:0] rdata_o,
    output logic          data_rd_o,
    output logic          err_reset_o,
    output logic          par_en_o
);
    typedef struct packed {
        logic          rd_n_prev;
        logic [DW-1:0] ctrl;
    } hif_t;

    hif_t hif_d, hif_q;
    logic rd_start;
    logic ctrl_wr;

    always_comb begin
        hif_d           = hif_q;
        rd_start        = hif_q.rd_n_prev & ~rd_n_i;
        ctrl_wr         = wr_i & (host_sel_e'(sel_i) == SEL_CTRL);
        hif_d.rd_n_prev = rd_n_i;
        if (ctrl_wr) begin
            hif_d.ctrl                = wdata_i;
            hif_d.ctrl[CTRL_ERST_BIT] = 1'b0;
        end
        data_rd_o   = rd_start & (host_sel_e'(sel_i) == SEL_DATA);
        err_reset_o = ctrl_wr & wdata_i[CTRL_ERST_BIT];
        par_en_o    = hif_q.ctrl[CTRL_PARS_BIT];
        rdata_o     = '0;
        case (host_sel_e'(sel_i))
            SEL_DATA: if (nonempty_i) rdata_o = head_data_i;
            SEL_STAT: if (nonempty_i) rdata_o = DW'(head_stat_i);
            SEL_CTRL: rdata_o = hif_q.ctrl;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hif_q.rd_n_prev <= 1'b1;
            hif_q.ctrl      <= '0;
        end else begin
            hif_q <= hif_d;
        end
    end

endmodule

// File: rtl/rxq_lock_ctl.sv
`timescale 1ns/1ps
module rxq_lock_ctl
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     nonempty_i,
    input  rx_stat_t head_stat_i,
    input  logic     par_en_i,
    input  logic     data_rd_i,
    input  logic     err_reset_i,
    output logic     pop_o,
    output logic     locked_o,
    output logic     dreq_n_o,
    output logic     sc_irq_o
);
    typedef struct packed {
        logic ack;
        logic hold;
    } lk_t;

    lk_t  lk_d, lk_q;
    logic locked;

    always_comb begin
        lk_d   = lk_q;
        locked = nonempty_i & is_special(head_stat_i, par_en_i) & ~lk_q.ack;
        pop_o  = data_rd_i & nonempty_i & ~locked;
        if (pop_o)                     lk_d.ack = 1'b0;
        else if (err_reset_i && locked) lk_d.ack = 1'b1;
        lk_d.hold = data_rd_i;
        locked_o  = locked;
        sc_irq_o  = locked;
        dreq_n_o  = ~(nonempty_i & ~locked) | lk_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

endmodule

// File: rtl/rx_fifo_errlock.sv
`timescale 1ns/1ps
module rx_fifo_errlock
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    input  logic          push_par_err,
    input  logic          push_frm_err,
    input  logic [1:0]    host_sel,
    input  logic          host_rd_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          dreq_n,
    output logic          sc_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_stat_t      push_stat;
    rx_stat_t      head_stat;
    logic [DW-1:0] head_data;
    logic [CW-1:0] fifo_count;
    logic          nonempty;
    logic          fifo_pop;
    logic          data_rd;
    logic          err_reset;
    logic          par_en;
    logic          locked;

    always_comb begin
        push_stat.frm = push_frm_err;
        push_stat.ovr = 1'b0;
        push_stat.par = push_par_err;
    end

    assign nonempty = (fifo_count != '0);

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_valid),
        .push_data_i (push_data),
        .push_stat_i (push_stat),
        .pop_i       (fifo_pop),
        .head_data_o (head_data),
        .head_stat_o (head_stat),
        .count_o     (fifo_count)
    );

    rxq_host_if #(.DW(DW)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (host_sel),
        .rd_n_i      (host_rd_n),
        .wr_i        (host_wr),
        .wdata_i     (host_wdata),
        .nonempty_i  (nonempty),
        .head_data_i (head_data),
        .head_stat_i (head_stat),
        .rdata_o     (host_rdata),
        .data_rd_o   (data_rd),
        .err_reset_o (err_reset),
        .par_en_o    (par_en)
    );

    rxq_lock_ctl u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .nonempty_i  (nonempty),
        .head_stat_i (head_stat),
        .par_en_i    (par_en),
        .data_rd_i   (data_rd),
        .err_reset_i (err_reset),
        .pop_o       (fifo_pop),
        .locked_o    (locked),
        .dreq_n_o    (dreq_n),
        .sc_irq_o    (sc_irq)
    );

endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
    parameter int DEPTH = 3,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dreq_n,
    input logic          sc_irq,
    input logic          locked,
    input logic [CW-1:0] count,
    input logic [2:0]    head_stat,
    input logic          data_rd,
    input logic          pop
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (dreq_n && !sc_irq));

    p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> dreq_n);

    p_lock_blocks_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_irq |-> dreq_n);

    p_lock_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !pop);

    p_lock_holds_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_irq && $past(sc_irq)) |-> $stable(head_stat));

    p_data_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> dreq_n);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

bind rx_fifo_errlock rxq_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq_n    (dreq_n),
    .sc_irq    (sc_irq),
    .locked    (locked),
    .count     (fifo_count),
    .head_stat (head_stat),
    .data_rd   (data_rd),
    .pop       (fifo_pop)
);

// File: tb/sim_rx_fifo_errlock.sv
`timescale 1ns/1ps
module sim_rx_fifo_errlock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_par_err = 1'b0;
    logic       push_frm_err = 1'b0;
    logic [1:0] host_sel = 2'd3;
    logic       host_rd_n = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       dreq_n;
    logic       sc_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_fifo_errlock u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_par_err(push_par_err), .push_frm_err(push_frm_err), .host_sel(host_sel),
        .host_rd_n(host_rd_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dreq_n(dreq_n), .sc_irq(sc_irq)
    );

    // behavioural reference model
    int   mq_d[$];
    int   mq_s[$];
    bit   m_ack, m_hold, m_rdn_prev;
    int   m_ctrl;
    bit   m_edge, m_lk, m_drd;

    function automatic bit m_locked();
        if (mq_d.size() == 0 || m_ack) return 1'b0;
        return mq_s[0][1] || mq_s[0][2] || (mq_s[0][0] && m_ctrl[1]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq_d.delete(); mq_s.delete();
            m_ack = 0; m_hold = 0; m_rdn_prev = 1; m_ctrl = 0;
        end else begin
            m_edge = m_rdn_prev && !host_rd_n;
            m_lk   = m_locked();
            m_drd  = m_edge && host_sel == 2'd0;
            if (m_drd && mq_d.size() > 0 && !m_lk) begin
                void'(mq_d.pop_front()); void'(mq_s.pop_front()); m_ack = 0;
            end else if (host_wr && host_sel == 2'd2 && host_wdata[0] && m_lk) begin
                m_ack = 1;
            end
            if (host_wr && host_sel == 2'd2) m_ctrl = int'(host_wdata) & 32'hFE;
            if (push_valid) begin
                if (mq_d.size() < 3) begin
                    mq_d.push_back(int'(push_data));
                    mq_s.push_back(int'({push_frm_err, 1'b0, push_par_err}));
                end else begin
                    mq_d[2] = int'(push_data);
                    mq_s[2] = int'({push_frm_err, 1'b1, push_par_err});
                end
            end
            m_hold = m_drd;
            m_rdn_prev = host_rd_n;
        end
    end

    function automatic int m_rdata();
        case (host_sel)
            2'd0: return (mq_d.size() > 0) ? mq_d[0] : 0;
            2'd1: return (mq_s.size() > 0) ? mq_s[0] : 0;
            2'd2: return m_ctrl;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk("R2 dreq_n vs model", int'(dreq_n),
                int'(!(mq_d.size() > 0 && !m_locked()) || m_hold));
            chk("R5 sc_irq vs model", int'(sc_irq), int'(m_locked()));
            chk("R3 rdata vs model", int'(host_rdata), m_rdata());
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_b(input logic [7:0] d, input bit p, input bit f);
        @(negedge clk);
        push_valid = 1; push_data = d; push_par_err = p; push_frm_err = f;
        @(negedge clk);
        push_valid = 0; push_par_err = 0; push_frm_err = 0;
    endtask

    task automatic peek(input logic [1:0] s, output int v);
        @(negedge clk);
        host_sel = s;
        #1 v = int'(host_rdata);
    endtask

    task automatic rd_reg(input logic [1:0] s, output int v);
        @(negedge clk);
        host_sel = s;
        #1 v = int'(host_rdata);
        host_rd_n = 0;
        @(posedge clk);
        #1;
        if (s == 2'd0) chk("R8 dreq_n high after data read", int'(dreq_n), 1);
        @(negedge clk);
        host_rd_n = 1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        host_sel = 2'd2; host_wr = 1; host_wdata = v;
        @(negedge clk);
        host_wr = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        idle(3);
        chk("R1 dreq_n in reset", int'(dreq_n), 1);
        chk("R1 sc_irq in reset", int'(sc_irq), 0);
        rst_n = 1;
        peek(2'd0, v); chk("R1 data reg empty", v, 0);
        peek(2'd1, v); chk("R1 status reg empty", v, 0);
        peek(2'd2, v); chk("R1 control cleared", v, 0);

        // clean bytes, order and request
        push_b(8'hA1, 0, 0); idle(1);
        chk("R2 request with data", int'(dreq_n), 0);
        push_b(8'hB2, 0, 0); push_b(8'hC3, 0, 0);
        rd_reg(2'd0, v); chk("R3 first byte", v, 8'hA1);
        idle(1); chk("R2 request returns", int'(dreq_n), 0);
        rd_reg(2'd0, v); chk("R3 second byte", v, 8'hB2);
        rd_reg(2'd0, v); chk("R3 third byte", v, 8'hC3);
        idle(2); chk("R2 empty no request", int'(dreq_n), 1);

        // status read and control write are side-effect free
        push_b(8'h11, 0, 0); idle(2);
        rd_reg(2'd1, v); chk("R4 clean status", v, 0);
        chk("R9 status read keeps request", int'(dreq_n), 0);
        wr_ctrl(8'h00); chk("R9 control write keeps request", int'(dreq_n), 0);
        peek(2'd0, v); chk("R4 status read did not pop", v, 8'h11);
        rd_reg(2'd0, v); idle(2);

        // parity without parity-special
        push_b(8'h22, 1, 0); idle(1);
        chk("R6 no lock irq", int'(sc_irq), 0);
        chk("R6 no lock request", int'(dreq_n), 0);
        peek(2'd1, v); chk("R4 parity bit0", v, 1);
        rd_reg(2'd0, v); chk("R6 parity byte pops", v, 8'h22);
        idle(2);

        // parity-special lock
        wr_ctrl(8'h82);
        peek(2'd2, v); chk("R11 control readback", v, 8'h82);
        push_b(8'h33, 0, 0); push_b(8'h44, 1, 0);
        rd_reg(2'd0, v); chk("R3 clean byte before error", v, 8'h33);
        idle(2);
        chk("R5 locked irq", int'(sc_irq), 1);
        chk("R5 locked request high", int'(dreq_n), 1);
        peek(2'd1, v); chk("R5 status shows parity", v, 1);
        rd_reg(2'd0, v); idle(2);
        peek(2'd0, v); chk("R5 locked data not popped", v, 8'h44);
        chk("R5 still locked", int'(sc_irq), 1);
        wr_ctrl(8'h83); idle(1);
        chk("R7 irq cleared", int'(sc_irq), 0);
        chk("R7 request follows data", int'(dreq_n), 0);
        peek(2'd2, v); chk("R11 reset bit not stored", v, 8'h82);
        rd_reg(2'd0, v); chk("R7 error byte read", v, 8'h44);
        idle(2); chk("R7 emptied", int'(dreq_n), 1);

        // framing lock regardless of enable
        wr_ctrl(8'h00);
        push_b(8'h55, 0, 1); idle(1);
        chk("R5 framing locks", int'(sc_irq), 1);
        peek(2'd1, v); chk("R4 framing bit2", v, 4);
        wr_ctrl(8'h01); idle(1);
        chk("R7 framing released", int'(sc_irq), 0);
        rd_reg(2'd0, v); chk("R7 framing byte read", v, 8'h55);
        idle(2);

        // overrun on full queue
        push_b(8'h61, 0, 0); push_b(8'h62, 0, 0);
        push_b(8'h63, 0, 0); push_b(8'h64, 0, 0);
        idle(1);
        peek(2'd1, v); chk("R10 head clean", v, 0);
        rd_reg(2'd0, v); chk("R10 head byte", v, 8'h61);
        rd_reg(2'd0, v); chk("R10 second byte", v, 8'h62);
        idle(2);
        peek(2'd0, v); chk("R10 newest replaced", v, 8'h64);
        peek(2'd1, v); chk("R10 overrun bit1", v, 2);
        chk("R10 overrun locks", int'(sc_irq), 1);
        wr_ctrl(8'h01);
        rd_reg(2'd0, v); chk("R10 replaced byte read", v, 8'h64);
        idle(2); chk("R10 queue drained", int'(dreq_n), 1);

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule